// File: doc/BRIEF.md
# Interrupt Log Ring Buffer

This block records interrupt events into a 32-word circular log that lives in shared RAM, so a host can see which interrupts happened recently and which bus command raised them. Each logged event occupies two consecutive words: an identification word, whose set bits name the interrupt types that occurred, followed by an address word. For a message-originated entry the address word is the descriptor-table address of the command's control word. For a hardware-originated entry it is zero. Sixteen entries fit in the ring. Once the ring is full, each new entry overwrites the oldest one.

Event strobes are masked by an enable register. The bits of the identification word are split into two classes: the upper half (bits 15:8) holds the hardware types and the lower half (bits 7:0) holds the message types. Message types that fire together merge into one entry and raise the message interrupt pin once. Hardware and message events in the same cycle produce two entries, with the hardware entry first. Each class drives its own interrupt pin. The pin stays high until its acknowledge input is sampled high.

The block has one RAM write port, so an entry takes two cycles to write. Events that arrive while a write is in progress are held in a per-class pending word. They are merged into the next entry of their class, and that entry carries the latest message address. The asynchronous reset `rst_n` is expected to be released synchronously to `clk`.

Top module: `irq_log_ring`

## Requirements
- R1: After `rst_n` low, the log pointer reads 0x0040, both interrupt pins are low and no RAM write is issued until an enabled event arrives.
- R2: An event strobe whose bit is clear in `int_en_i` causes no RAM write and no pin change.
- R3: An identification word holds exactly the enabled types that occurred. Bits 15:8 are the hardware types and bits 7:0 are the message types. One word never mixes the two classes, and it is never zero.
- R4: When the writer is idle, the identification word is written at the pointer address in the cycle after the strobe. The address word is written at the pointer address plus 1 in the next cycle. All writes fall in 0x0040..0x005F.
- R5: A message entry's address word equals `ctrl_addr_i` as sampled with the message event. A hardware entry's address word is 0x0000.
- R6: Several message types strobed in the same cycle produce a single entry and a single assertion of `irq_msg_o`.
- R7: Hardware and message events in the same cycle produce two entries in four consecutive write cycles, the hardware entry first.
- R8: The pointer advances by 2 after each address word and wraps from 0x005E to 0x0040. After exactly 16 entries from reset it reads 0x0040 again.
- R9: A pin goes high in the cycle after its class's identification word is written. It then stays high until its acknowledge is sampled high, and a new set in the same cycle takes precedence over the acknowledge.
- R10: A high `soft_rst_i` has the effect of R1 at the next edge: pending events are dropped and any entry in progress is abandoned.
- R11: Events of a class that arrive while its entry cannot start yet are merged into the next entry of that class, and a merged message entry carries the most recent control-word address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Synchronous software reset |
| evt_i | input | 16 | Per-type interrupt event strobes |
| int_en_i | input | 16 | Interrupt enable register value |
| ctrl_addr_i | input | 16 | Control-word address of the current message |
| ack_msg_i | input | 1 | Acknowledge for the message interrupt pin |
| ack_hw_i | input | 1 | Acknowledge for the hardware interrupt pin |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | 16 | RAM write address |
| ram_wdata_o | output | 16 | RAM write data |
| log_ptr_o | output | 16 | Address where the next entry will be written |
| irq_msg_o | output | 1 | Message interrupt pin |
| irq_hw_o | output | 1 | Hardware interrupt pin |

## Verification
A corrupted pointer appears at once on `log_ptr_o`. It also shows on the next write address, no later than one cycle after the next strobe. A wrong pending word or a wrong writer state shows up as a missing, extra or merged identification word. Because the RAM port is combinational from state, that error is visible in the first cycle of the affected entry. A pin flop that ignores the acknowledge, or sets for the wrong class, is exposed in the cycle after the acknowledge or the identification write. The bench compares every output on every clock against a behavioural model, so each of these faults is caught in the cycle it first reaches a port.

// File: rtl/irq_log_pkg.sv
package irq_log_pkg;
  typedef enum logic [1:0] {
    WR_IDLE = 2'd0,
    WR_ID   = 2'd1,
    WR_ADDR = 2'd2
  } wr_state_e;
endpackage

// File: rtl/irq_log_collect.sv
// Masks event strobes and holds per-class pending words until the writer takes them.
module irq_log_collect #(
  parameter int unsigned     W       = 16,
  parameter logic [W-1:0]    HW_MASK = 16'hFF00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst_i,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] ctrl_addr_i,
  input  logic         take_hw_i,
  input  logic         take_msg_i,
  output logic [W-1:0] eff_hw_o,
  output logic [W-1:0] eff_msg_o,
  output logic [W-1:0] eff_addr_o
);
  logic [W-1:0] new_hw, new_msg;
  logic [W-1:0] pend_hw_q, pend_hw_d;
  logic [W-1:0] pend_msg_q, pend_msg_d;
  logic [W-1:0] pend_addr_q, pend_addr_d;

  always_comb begin
    new_hw     = evt_i & en_i & HW_MASK;
    new_msg    = evt_i & en_i & ~HW_MASK;
    eff_hw_o   = pend_hw_q | new_hw;
    eff_msg_o  = pend_msg_q | new_msg;
    eff_addr_o = (|new_msg) ? ctrl_addr_i : pend_addr_q;
    pend_hw_d  = take_hw_i  ? '0 : eff_hw_o;
    pend_msg_d = take_msg_i ? '0 : eff_msg_o;
    pend_addr_d = eff_addr_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_hw_q   <= '0;
      pend_msg_q  <= '0;
      pend_addr_q <= '0;
    end else if (soft_rst_i) begin
      pend_hw_q   <= '0;
      pend_msg_q  <= '0;
      pend_addr_q <= '0;
    end else begin
      pend_hw_q   <= pend_hw_d;
      pend_msg_q  <= pend_msg_d;
      pend_addr_q <= pend_addr_d;
    end
  end
endmodule

// File: rtl/irq_log_writer.sv
// Two-cycle entry writer and ring pointer.
module irq_log_writer
  import irq_log_pkg::*;
#(
  parameter int unsigned W          = 16,
  parameter int unsigned RING_BASE  = 16'h0040,
  parameter int unsigned RING_WORDS = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst_i,
  input  logic [W-1:0] eff_hw_i,
  input  logic [W-1:0] eff_msg_i,
  input  logic [W-1:0] eff_addr_i,
  output logic         take_hw_o,
  output logic         take_msg_o,
  output logic         ram_we_o,
  output logic [W-1:0] ram_addr_o,
  output logic [W-1:0] ram_wdata_o,
  output logic [W-1:0] ptr_o,
  output logic         logged_hw_o,
  output logic         logged_msg_o
);
  localparam logic [W-1:0] BASE_W = W'(RING_BASE);
  localparam logic [W-1:0] END_W  = W'(RING_BASE + RING_WORDS);
  localparam logic [W-1:0] ONE_W  = W'(1);
  localparam logic [W-1:0] TWO_W  = W'(2);

  wr_state_e    state_q, state_d;
  logic [W-1:0] cur_id_q, cur_id_d;
  logic [W-1:0] cur_addr_q, cur_addr_d;
  logic         cur_hw_q, cur_hw_d;
  logic [W-1:0] ptr_q, ptr_d, ptr_step;
  logic         free, load_en, ptr_en;

  always_comb begin
    free       = (state_q != WR_ID);
    take_hw_o  = free && (|eff_hw_i);
    take_msg_o = free && !(|eff_hw_i) && (|eff_msg_i);
    load_en    = take_hw_o || take_msg_o;
    ptr_en     = (state_q == WR_ADDR);
    ptr_step   = ptr_q + TWO_W;
    ptr_d      = (ptr_step == END_W) ? BASE_W : ptr_step;
    cur_id_d   = take_hw_o ? eff_hw_i : eff_msg_i;
    cur_addr_d = take_hw_o ? '0 : eff_addr_i;
    cur_hw_d   = take_hw_o;
    if (load_en) begin
      state_d = WR_ID;
    end else begin
      case (state_q)
        WR_ID:   state_d = WR_ADDR;
        default: state_d = WR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WR_IDLE;
      ptr_q   <= BASE_W;
    end else if (soft_rst_i) begin
      state_q <= WR_IDLE;
      ptr_q   <= BASE_W;
    end else begin
      state_q <= state_d;
      if (ptr_en) ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_id_q   <= '0;
      cur_addr_q <= '0;
      cur_hw_q   <= 1'b0;
    end else if (load_en) begin
      cur_id_q   <= cur_id_d;
      cur_addr_q <= cur_addr_d;
      cur_hw_q   <= cur_hw_d;
    end
  end

  always_comb begin
    ram_we_o     = (state_q != WR_IDLE);
    ram_addr_o   = (state_q == WR_ADDR) ? (ptr_q + ONE_W) : ptr_q;
    ram_wdata_o  = (state_q == WR_ADDR) ? cur_addr_q : cur_id_q;
    ptr_o        = ptr_q;
    logged_hw_o  = (state_q == WR_ID) && cur_hw_q;
    logged_msg_o = (state_q == WR_ID) && !cur_hw_q;
  end
endmodule

// File: rtl/irq_log_pin.sv
// Interrupt pin: set by a logging write, cleared by a sampled acknowledge.
module irq_log_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst_i,
  input  logic set_i,
  input  logic ack_i,
  output logic irq_o
);
  logic irq_q, irq_d;

  always_comb begin
    if (set_i)      irq_d = 1'b1;
    else if (ack_i) irq_d = 1'b0;
    else            irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          irq_q <= 1'b0;
    else if (soft_rst_i) irq_q <= 1'b0;
    else                 irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_log_ring.sv
module irq_log_ring #(
  parameter int unsigned  W          = 16,
  parameter int unsigned  RING_BASE  = 16'h0040,
  parameter int unsigned  RING_WORDS = 32,
  parameter logic [W-1:0] HW_MASK    = 16'hFF00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst_i,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] int_en_i,
  input  logic [W-1:0] ctrl_addr_i,
  input  logic         ack_msg_i,
  input  logic         ack_hw_i,
  output logic         ram_we_o,
  output logic [W-1:0] ram_addr_o,
  output logic [W-1:0] ram_wdata_o,
  output logic [W-1:0] log_ptr_o,
  output logic         irq_msg_o,
  output logic         irq_hw_o
);
  localparam int unsigned N_PINS = 2;

  logic [W-1:0] eff_hw, eff_msg, eff_addr;
  logic         take_hw, take_msg, logged_hw, logged_msg;
  logic [N_PINS-1:0] pin_set, pin_ack, pin_q;

  irq_log_collect #(.W(W), .HW_MASK(HW_MASK)) collect_i (
    .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i),
    .evt_i(evt_i), .en_i(int_en_i), .ctrl_addr_i(ctrl_addr_i),
    .take_hw_i(take_hw), .take_msg_i(take_msg),
    .eff_hw_o(eff_hw), .eff_msg_o(eff_msg), .eff_addr_o(eff_addr)
  );

  irq_log_writer #(.W(W), .RING_BASE(RING_BASE), .RING_WORDS(RING_WORDS)) writer_i (
    .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i),
    .eff_hw_i(eff_hw), .eff_msg_i(eff_msg), .eff_addr_i(eff_addr),
    .take_hw_o(take_hw), .take_msg_o(take_msg),
    .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o), .ram_wdata_o(ram_wdata_o),
    .ptr_o(log_ptr_o), .logged_hw_o(logged_hw), .logged_msg_o(logged_msg)
  );

  // index 0: message class, index 1: hardware class
  assign pin_set = {logged_hw, logged_msg};
  assign pin_ack = {ack_hw_i, ack_msg_i};

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    irq_log_pin pin_i (
      .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i),
      .set_i(pin_set[g]), .ack_i(pin_ack[g]), .irq_o(pin_q[g])
    );
  end

  assign irq_msg_o = pin_q[0];
  assign irq_hw_o  = pin_q[1];
endmodule

// File: rtl/irq_log_ring_chk.sv
module irq_log_ring_chk #(
  parameter int unsigned  W          = 16,
  parameter int unsigned  RING_BASE  = 16'h0040,
  parameter int unsigned  RING_WORDS = 32,
  parameter logic [W-1:0] HW_MASK    = 16'hFF00
) (
  input logic         clk,
  input logic         rst_n,
  input logic         soft_rst_i,
  input logic         ack_msg_i,
  input logic         ack_hw_i,
  input logic         ram_we_o,
  input logic [W-1:0] ram_addr_o,
  input logic [W-1:0] ram_wdata_o,
  input logic [W-1:0] log_ptr_o,
  input logic         irq_msg_o,
  input logic         irq_hw_o
);
  localparam logic [W-1:0] LO = W'(RING_BASE);
  localparam logic [W-1:0] HI = W'(RING_BASE + RING_WORDS);

  logic id_wr, id_hw, id_msg;
  assign id_wr  = ram_we_o && !ram_addr_o[0];
  assign id_hw  = id_wr && ((ram_wdata_o & HW_MASK) != '0);
  assign id_msg = id_wr && ((ram_wdata_o & ~HW_MASK) != '0);

  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_i |=> (log_ptr_o == LO) && !irq_msg_o && !irq_hw_o && !ram_we_o);

  assert_ptr_in_ring_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (log_ptr_o >= LO) && (log_ptr_o < HI) && !log_ptr_o[0]);

  assert_write_in_ring_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |-> (ram_addr_o >= LO) && (ram_addr_o < HI));

  assert_addr_word_follows_R4: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
    id_wr |=> ram_we_o && (ram_addr_o == $past(ram_addr_o) + W'(1)));

  assert_id_single_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
    id_wr |-> (ram_wdata_o != '0) && !(id_hw && id_msg));

  assert_hw_null_addr_R5: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
    id_hw |=> (ram_wdata_o == '0));

  assert_msg_pin_source_R9: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
    $rose(irq_msg_o) |-> $past(id_msg));

  assert_hw_pin_source_R9: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
    $rose(irq_hw_o) |-> $past(id_hw));

  assert_msg_ack_R9: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
    (ack_msg_i && !id_msg) |=> !irq_msg_o);

  assert_hw_ack_R9: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
    (ack_hw_i && !id_hw) |=> !irq_hw_o);
endmodule

bind irq_log_ring irq_log_ring_chk #(
  .W(W), .RING_BASE(RING_BASE), .RING_WORDS(RING_WORDS), .HW_MASK(HW_MASK)
) chk_i (
  .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i),
  .ack_msg_i(ack_msg_i), .ack_hw_i(ack_hw_i),
  .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o), .ram_wdata_o(ram_wdata_o),
  .log_ptr_o(log_ptr_o), .irq_msg_o(irq_msg_o), .irq_hw_o(irq_hw_o)
);

// File: tb/irq_log_ring_tb_top.sv
`timescale 1ns/1ps
module irq_log_ring_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst_i = 1'b0;
  logic [15:0] evt_i = '0;
  logic [15:0] int_en_i = '0;
  logic [15:0] ctrl_addr_i = '0;
  logic        ack_msg_i = 1'b0;
  logic        ack_hw_i = 1'b0;
  logic        ram_we_o;
  logic [15:0] ram_addr_o, ram_wdata_o, log_ptr_o;
  logic        irq_msg_o, irq_hw_o;

  always #5 clk = ~clk;

  irq_log_ring dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i),
    .evt_i(evt_i), .int_en_i(int_en_i), .ctrl_addr_i(ctrl_addr_i),
    .ack_msg_i(ack_msg_i), .ack_hw_i(ack_hw_i),
    .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o), .ram_wdata_o(ram_wdata_o),
    .log_ptr_o(log_ptr_o), .irq_msg_o(irq_msg_o), .irq_hw_o(irq_hw_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  string phase = "R1";

  // ---------------- behavioural reference model ----------------
  int m_ptr = 'h40;
  int p_hw = 0, p_msg = 0, p_addr = 0;
  int m_irq_hw = 0, m_irq_msg = 0;
  int qa[$];
  int qd[$];
  int qk[$];   // 0: hw id word, 1: msg id word, 2: address word

  task automatic model_clear();
    m_ptr = 'h40; p_hw = 0; p_msg = 0; p_addr = 0;
    m_irq_hw = 0; m_irq_msg = 0;
    qa.delete(); qd.delete(); qk.delete();
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || soft_rst_i) begin
      model_clear();
    end else begin
      int nh, nm, eh, em, ea, k;
      bit is_free, set_h, set_m;
      nh = int'(evt_i & int_en_i) & 'hFF00;
      nm = int'(evt_i & int_en_i) & 'h00FF;
      eh = p_hw | nh;
      em = p_msg | nm;
      ea = (nm != 0) ? int'(ctrl_addr_i) : p_addr;
      is_free = (qa.size() <= 1);
      set_h = 0; set_m = 0;
      if (qa.size() > 0) begin
        k = qk.pop_front();
        void'(qa.pop_front());
        void'(qd.pop_front());
        if (k == 0) set_h = 1;
        if (k == 1) set_m = 1;
        if (k == 2) m_ptr = (m_ptr + 2 == 'h60) ? 'h40 : m_ptr + 2;
      end
      m_irq_hw  = set_h ? 1 : (ack_hw_i  ? 0 : m_irq_hw);
      m_irq_msg = set_m ? 1 : (ack_msg_i ? 0 : m_irq_msg);
      if (is_free && eh != 0) begin
        qa.push_back(m_ptr);     qd.push_back(eh); qk.push_back(0);
        qa.push_back(m_ptr + 1); qd.push_back(0);  qk.push_back(2);
        p_hw = 0; p_msg = em;
      end else if (is_free && em != 0) begin
        qa.push_back(m_ptr);     qd.push_back(em); qk.push_back(1);
        qa.push_back(m_ptr + 1); qd.push_back(ea); qk.push_back(2);
        p_hw = 0; p_msg = 0;
      end else begin
        p_hw = eh; p_msg = em;
      end
      p_addr = ea;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (!done) begin
      bit exp_we;
      int ea, ed;
      exp_we = (qa.size() > 0);
      ea = exp_we ? qa[0] : 0;
      ed = exp_we ? qd[0] : 0;
      n_cmp++;
      if (ram_we_o !== exp_we || log_ptr_o !== 16'(m_ptr) ||
          irq_hw_o !== m_irq_hw[0] || irq_msg_o !== m_irq_msg[0] ||
          (exp_we && (ram_addr_o !== 16'(ea) || ram_wdata_o !== 16'(ed)))) begin
        n_bad++;
        $display("FAIL %s: we=%0b addr=%h data=%h ptr=%h irq_hw=%0b irq_msg=%0b expected we=%0b addr=%h data=%h ptr=%h irq_hw=%0d irq_msg=%0d",
                 phase, ram_we_o, ram_addr_o, ram_wdata_o, log_ptr_o, irq_hw_o, irq_msg_o,
                 exp_we, 16'(ea), 16'(ed), 16'(m_ptr), m_irq_hw, m_irq_msg);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(input logic [15:0] e, input logic [15:0] a);
    @(negedge clk);
    evt_i = e; ctrl_addr_i = a;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic soft_reset();
    @(negedge clk); soft_rst_i = 1'b1;
    @(negedge clk); soft_rst_i = 1'b0;
  endtask

  // ---------------- scenario ----------------
  initial begin
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    phase = "R1";
    check("R1 ptr", log_ptr_o, 16'h0040);
    check("R1 pins", {14'd0, irq_hw_o, irq_msg_o}, 16'h0000);
    check("R1 we", {15'd0, ram_we_o}, 16'h0000);

    phase = "R2";
    int_en_i = 16'h00FF;
    strobe(16'h0100, 16'h1111);
    idle(4);
    check("R2 ptr", log_ptr_o, 16'h0040);
    check("R2 irq_hw", {15'd0, irq_hw_o}, 16'h0000);

    phase = "R4_R5";
    int_en_i = 16'hFFFF;
    strobe(16'h0001, 16'h1234);
    idle(3);
    check("R4 ptr", log_ptr_o, 16'h0042);
    check("R9 irq_msg held", {15'd0, irq_msg_o}, 16'h0001);

    phase = "R9";
    idle(6);
    check("R9 irq_msg still held", {15'd0, irq_msg_o}, 16'h0001);
    @(negedge clk); ack_msg_i = 1'b1;
    @(negedge clk); ack_msg_i = 1'b0;
    check("R9 irq_msg cleared", {15'd0, irq_msg_o}, 16'h0000);

    phase = "R6";
    strobe(16'h0009, 16'h2222);
    idle(4);
    check("R6 one entry", log_ptr_o, 16'h0044);

    phase = "R7";
    strobe(16'h0102, 16'h3333);
    idle(6);
    check("R7 two entries", log_ptr_o, 16'h0048);
    check("R7 both pins", {14'd0, irq_hw_o, irq_msg_o}, 16'h0003);
    @(negedge clk); ack_hw_i = 1'b1; ack_msg_i = 1'b1;
    @(negedge clk); ack_hw_i = 1'b0; ack_msg_i = 1'b0;

    phase = "R11";
    @(negedge clk); evt_i = 16'h0001; ctrl_addr_i = 16'h4444;
    @(negedge clk); evt_i = 16'h0004; ctrl_addr_i = 16'h5555;
    @(negedge clk); evt_i = 16'h0200;
    @(negedge clk); evt_i = 16'h0010; ctrl_addr_i = 16'h6666;
    @(negedge clk); evt_i = '0;
    idle(10);

    phase = "R3";
    int_en_i = 16'h0F0F;
    strobe(16'hFFFF, 16'h7777);
    idle(6);
    int_en_i = 16'hFFFF;

    phase = "R10";
    strobe(16'h0401, 16'h8888);
    soft_reset();
    check("R10 ptr", log_ptr_o, 16'h0040);
    check("R10 pins", {14'd0, irq_hw_o, irq_msg_o}, 16'h0000);
    idle(5);
    check("R10 no write after", log_ptr_o, 16'h0040);

    phase = "R8";
    for (int i = 0; i < 16; i++) begin
      strobe((i % 2 == 0) ? 16'h0800 : 16'h0020, 16'(16'h9000 + i));
      idle(2);
    end
    idle(3);
    check("R8 wrap after 16", log_ptr_o, 16'h0040);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); evt_i = 16'h1080 >> (i % 3); ctrl_addr_i = 16'(16'hA000 + i);
    end
    @(negedge clk); evt_i = '0;
    idle(20);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule